// File: doc/BRIEF.md
# Three-Wide In-Order Issue Group with Rollback

This block is the issue stage behind a three-wide, in-order decode. Each cycle it builds a group of three instruction slots, with slot 0 the oldest. Each slot carries a valid bit, a PC, a destination register and two source registers. Instructions that were held back in the previous cycle fill the lowest slots, in their original order. The remaining slots take newly fetched instructions, in fetch order.

The block then looks for read-after-write dependencies inside the group. The oldest slot that reads a register written by an older valid slot in the same group is withheld, together with every slot younger than it. The slots ahead of it are issued.

The withheld tail is kept in a small buffer and goes to the front of the next group. The number of slots it occupies is reported to the fetch side, so that fetch presents only as many new instructions as there are free slots. A flush cancels both the group being issued and the buffered tail.

Top module: `issue_group_rollback`

## Requirements
- R1: While reset is asserted, every issue valid bit is 0 and the rollback count is 0.
- R2: A group with no internal dependency is issued whole on the clock edge after it is presented, one cycle of latency. Output slot i carries the PC and registers of group slot i, and the rollback count after that edge is 0.
- R3: Slot y depends on an older slot o (o < y) only when all of the following hold: both slots are valid, the destination register of slot o is non-zero, and it equals rs1 or rs2 of slot y. A zero destination or an invalid older slot never creates a dependency.
- R4: Let k be the lowest dependent slot. Slots below k are issued, output slots k and above are invalid, and the rollback count becomes 3 - k (1 or 2). Slot 0 is never withheld, so the count never exceeds 2.
- R5: Withheld instructions occupy the lowest slots of the next group, in their original order. They are followed by fetch slots 0 up to 2 - count. Fetch slots at or above 3 minus the current rollback count are ignored.
- R6: A re-issued instruction is checked again against the slots that now precede it in the new group. It is withheld again if it still depends on one of them.
- R7: When flush is high at a clock edge, every issue valid bit is 0 after that edge and the rollback count is 0. The buffered instructions are discarded, and the next group holds only fetched instructions.
- R8: An issued group never contains a dependency, as defined in R3, between two of its valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Cancel the issued group and the buffered instructions |
| fetchValid | input | 3 | Valid bit per fetched slot, bit 0 oldest |
| fetchPc | input | 96 | PC per fetched slot, slot i at bits [32i+31:32i] |
| fetchRd | input | 15 | Destination register per slot, slot i at bits [5i+4:5i] |
| fetchRs1 | input | 15 | First source register per slot |
| fetchRs2 | input | 15 | Second source register per slot |
| issueValid | output | 3 | Valid bit per issued slot |
| issuePc | output | 96 | PC per issued slot |
| issueRd | output | 15 | Destination register per issued slot |
| issueRs1 | output | 15 | First source register per issued slot |
| issueRs2 | output | 15 | Second source register per issued slot |
| rollbackCnt | output | 2 | Number of group slots taken by buffered instructions in the next cycle |

## Verification
The bench covers several kinds of group:
- Groups whose would-be dependency comes from register zero or from an invalid older slot. A design that skips either qualifier withholds slots for no reason.
- Groups where slot 1 depends on slot 0, and groups where only slot 2 depends on slot 1. A design that cuts at the wrong slot shows a wrong count or wrong issue valid bits.
- The cycle after a rollback. Live-looking junk is placed in the fetch slots that should be ignored. A design that merges badly issues that junk or loses program order.

Two further cases close the set. In a dependency chain, the re-issued head must hold back its successor again. After a flush, a design that does not clear its buffer brings stale instructions back.

// File: rtl/issue_group_pkg.sv
package issue_group_pkg;
  localparam int unsigned LANES  = 3;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned CNT_W  = (LANES > 2) ? $clog2(LANES) : 1;

  typedef struct packed {
    logic              valid;
    logic [XLEN-1:0]   pc;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } slot_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] issueMask;
    logic [CNT_W-1:0] holdCnt;
    logic             flush;
  } strobe_t;
endpackage

// File: rtl/issue_group_control.sv
module issue_group_control
  import issue_group_pkg::*;
(
  input  logic    flush,
  input  slot_t   groupSlots [LANES],
  output strobe_t strobes
);
  logic [LANES-1:0] slotDep;
  logic [CNT_W:0]   cut;

  genvar y, o;
  generate
    for (y = 0; y < LANES; y++) begin : g_young
      logic [LANES-1:0] hit;
      for (o = 0; o < LANES; o++) begin : g_old
        if (o < y) begin : g_chk
          assign hit[o] = groupSlots[o].valid && (groupSlots[o].rd != '0) &&
                          ((groupSlots[o].rd == groupSlots[y].rs1) ||
                           (groupSlots[o].rd == groupSlots[y].rs2));
        end else begin : g_none
          assign hit[o] = 1'b0;
        end
      end
      assign slotDep[y] = groupSlots[y].valid && (|hit);
    end
  endgenerate

  // lowest dependent slot (slot 0 excluded) marks the cut
  always_comb begin
    cut = (CNT_W+1)'(LANES);
    for (int i = LANES - 1; i >= 1; i--) begin
      if (slotDep[i]) cut = (CNT_W+1)'(i);
    end
  end

  always_comb begin
    strobes = '0;
    for (int i = 0; i < LANES; i++) begin
      strobes.issueMask[i] = ((CNT_W+1)'(i) < cut);
    end
    strobes.holdCnt = CNT_W'((CNT_W+1)'(LANES) - cut);
    strobes.flush   = flush;
  end
endmodule

// File: rtl/issue_group_datapath.sv
module issue_group_datapath
  import issue_group_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            fetchSlots [LANES],
  input  strobe_t          strobes,
  output slot_t            groupSlots [LANES],
  output slot_t            issueSlots [LANES],
  output logic [CNT_W-1:0] heldCnt
);
  slot_t heldBuf [LANES];

  // buffered tail first, then fetch slots from 0 upward
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(heldCnt)) groupSlots[i] = heldBuf[i];
      else                   groupSlots[i] = fetchSlots[i - int'(heldCnt)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldCnt <= '0;
      for (int i = 0; i < LANES; i++) begin
        heldBuf[i]    <= '0;
        issueSlots[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        issueSlots[i]       <= groupSlots[i];
        issueSlots[i].valid <= groupSlots[i].valid & strobes.issueMask[i] & ~strobes.flush;
        if (i < int'(strobes.holdCnt))
          heldBuf[i] <= groupSlots[LANES - int'(strobes.holdCnt) + i];
      end
      heldCnt <= strobes.flush ? '0 : strobes.holdCnt;
    end
  end
endmodule

// File: rtl/issue_group_rollback.sv
module issue_group_rollback
  import issue_group_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [LANES-1:0]        fetchValid,
  input  logic [LANES*XLEN-1:0]   fetchPc,
  input  logic [LANES*REG_AW-1:0] fetchRd,
  input  logic [LANES*REG_AW-1:0] fetchRs1,
  input  logic [LANES*REG_AW-1:0] fetchRs2,
  output logic [LANES-1:0]        issueValid,
  output logic [LANES*XLEN-1:0]   issuePc,
  output logic [LANES*REG_AW-1:0] issueRd,
  output logic [LANES*REG_AW-1:0] issueRs1,
  output logic [LANES*REG_AW-1:0] issueRs2,
  output logic [CNT_W-1:0]        rollbackCnt
);
  slot_t   fetchSlots [LANES];
  slot_t   groupSlots [LANES];
  slot_t   issueSlots [LANES];
  strobe_t strobes;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      assign fetchSlots[i].valid = fetchValid[i];
      assign fetchSlots[i].pc    = fetchPc[i*XLEN +: XLEN];
      assign fetchSlots[i].rd    = fetchRd[i*REG_AW +: REG_AW];
      assign fetchSlots[i].rs1   = fetchRs1[i*REG_AW +: REG_AW];
      assign fetchSlots[i].rs2   = fetchRs2[i*REG_AW +: REG_AW];
      assign issueValid[i]               = issueSlots[i].valid;
      assign issuePc[i*XLEN +: XLEN]     = issueSlots[i].pc;
      assign issueRd[i*REG_AW +: REG_AW]  = issueSlots[i].rd;
      assign issueRs1[i*REG_AW +: REG_AW] = issueSlots[i].rs1;
      assign issueRs2[i*REG_AW +: REG_AW] = issueSlots[i].rs2;
    end
  endgenerate

  issue_group_control u_ctrl (
    .flush      (flush),
    .groupSlots (groupSlots),
    .strobes    (strobes)
  );

  issue_group_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchSlots (fetchSlots),
    .strobes    (strobes),
    .groupSlots (groupSlots),
    .issueSlots (issueSlots),
    .heldCnt    (rollbackCnt)
  );
endmodule

// File: rtl/issue_group_rollback_chk.sv
module issue_group_rollback_chk
  import issue_group_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic [LANES-1:0]        issueValid,
  input logic [LANES*REG_AW-1:0] issueRd,
  input logic [LANES*REG_AW-1:0] issueRs1,
  input logic [LANES*REG_AW-1:0] issueRs2,
  input logic [CNT_W-1:0]        rollbackCnt
);
  logic outDep;

  always_comb begin
    outDep = 1'b0;
    for (int y = 1; y < LANES; y++) begin
      for (int o = 0; o < y; o++) begin
        if (issueValid[y] && issueValid[o] && (issueRd[o*REG_AW +: REG_AW] != '0) &&
            ((issueRd[o*REG_AW +: REG_AW] == issueRs1[y*REG_AW +: REG_AW]) ||
             (issueRd[o*REG_AW +: REG_AW] == issueRs2[y*REG_AW +: REG_AW])))
          outDep = 1'b1;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rollbackCnt) <= LANES - 1); // R4

  AST_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rollbackCnt != '0) |-> !issueValid[LANES-1]); // R4

  AST_HELD_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rollbackCnt != '0 && !flush) |=> issueValid[0]); // R5

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (issueValid == '0 && rollbackCnt == '0)); // R7

  AST_NO_GROUP_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    !outDep); // R8
endmodule

bind issue_group_rollback issue_group_rollback_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .issueValid  (issueValid),
  .issueRd     (issueRd),
  .issueRs1    (issueRs1),
  .issueRs2    (issueRs2),
  .rollbackCnt (rollbackCnt)
);

// File: tb/issue_group_rollback_tb.sv
module issue_group_rollback_tb;
  import issue_group_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [LANES-1:0]        fetchValid = '0;
  logic [LANES*XLEN-1:0]   fetchPc = '0;
  logic [LANES*REG_AW-1:0] fetchRd = '0, fetchRs1 = '0, fetchRs2 = '0;
  logic [LANES-1:0]        issueValid;
  logic [LANES*XLEN-1:0]   issuePc;
  logic [LANES*REG_AW-1:0] issueRd, issueRs1, issueRs2;
  logic [CNT_W-1:0]        rollbackCnt;

  always #5 clk = ~clk;

  issue_group_rollback u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchRd(fetchRd),
    .fetchRs1(fetchRs1), .fetchRs2(fetchRs2),
    .issueValid(issueValid), .issuePc(issuePc), .issueRd(issueRd),
    .issueRs1(issueRs1), .issueRs2(issueRs2), .rollbackCnt(rollbackCnt)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // staged fetch slots
  logic              fV [LANES];
  logic [XLEN-1:0]   fP [LANES];
  logic [REG_AW-1:0] fD [LANES], f1 [LANES], f2 [LANES];
  // reference model of the buffered tail
  logic              hV [LANES];
  logic [XLEN-1:0]   hP [LANES];
  logic [REG_AW-1:0] hD [LANES], h1 [LANES], h2 [LANES];
  int hCnt = 0;

  // scoreboard queues
  logic [LANES-1:0]      qV [$];
  logic [LANES*XLEN-1:0] qP [$];
  int                    qRb [$];
  string                 qTag [$];

  task automatic clearFetch();
    for (int i = 0; i < LANES; i++) begin
      fV[i] = 1'b0; fP[i] = '0; fD[i] = '0; f1[i] = '0; f2[i] = '0;
    end
  endtask

  task automatic setSlot(input int i, input logic v, input logic [XLEN-1:0] pc,
                         input logic [REG_AW-1:0] rd, input logic [REG_AW-1:0] a,
                         input logic [REG_AW-1:0] b);
    fV[i] = v; fP[i] = pc; fD[i] = rd; f1[i] = a; f2[i] = b;
  endtask

  // driver: compute expected outcome, push it, drive ports for one cycle
  task automatic step(input string tag, input logic fl);
    logic              mV [LANES];
    logic [XLEN-1:0]   mP [LANES];
    logic [REG_AW-1:0] mD [LANES], m1 [LANES], m2 [LANES];
    logic [LANES-1:0]      ev;
    logic [LANES*XLEN-1:0] ep;
    int k;
    for (int i = 0; i < LANES; i++) begin
      if (i < hCnt) begin
        mV[i] = hV[i]; mP[i] = hP[i]; mD[i] = hD[i]; m1[i] = h1[i]; m2[i] = h2[i];
      end else begin
        mV[i] = fV[i-hCnt]; mP[i] = fP[i-hCnt]; mD[i] = fD[i-hCnt];
        m1[i] = f1[i-hCnt]; m2[i] = f2[i-hCnt];
      end
    end
    k = LANES;
    for (int y = 1; y < LANES; y++)
      for (int o = 0; o < y; o++)
        if (k == LANES && mV[y] && mV[o] && mD[o] != 0 && (mD[o] == m1[y] || mD[o] == m2[y]))
          k = y;
    ev = '0; ep = '0;
    for (int i = 0; i < LANES; i++) begin
      ev[i] = !fl && (i < k) && mV[i];
      ep[i*XLEN +: XLEN] = mP[i];
    end
    if (fl) hCnt = 0;
    else begin
      for (int i = k; i < LANES; i++) begin
        hV[i-k] = mV[i]; hP[i-k] = mP[i]; hD[i-k] = mD[i]; h1[i-k] = m1[i]; h2[i-k] = m2[i];
      end
      hCnt = LANES - k;
    end
    qV.push_back(ev); qP.push_back(ep); qRb.push_back(hCnt); qTag.push_back(tag);
    for (int i = 0; i < LANES; i++) begin
      fetchValid[i] = fV[i];
      fetchPc[i*XLEN +: XLEN] = fP[i];
      fetchRd[i*REG_AW +: REG_AW] = fD[i];
      fetchRs1[i*REG_AW +: REG_AW] = f1[i];
      fetchRs2[i*REG_AW +: REG_AW] = f2[i];
    end
    flush = fl;
    @(negedge clk);
  endtask

  // monitor: pop one expected item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (qV.size() > 0) begin
        logic [LANES-1:0] ev;
        logic [LANES*XLEN-1:0] ep;
        int erb;
        string tag;
        bit bad;
        ev = qV.pop_front(); ep = qP.pop_front(); erb = qRb.pop_front(); tag = qTag.pop_front();
        bad = (issueValid !== ev) || (int'(rollbackCnt) != erb);
        for (int i = 0; i < LANES; i++)
          if (ev[i] && issuePc[i*XLEN +: XLEN] !== ep[i*XLEN +: XLEN]) bad = 1;
        checks++;
        if (bad) begin
          failures++;
          $display("FAIL %s: valid=%b pc=%h rb=%0d expected valid=%b pc=%h rb=%0d",
                   tag, issueValid, issuePc, rollbackCnt, ev, ep, erb);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearFetch();
    for (int i = 0; i < LANES; i++) begin
      hV[i] = 0; hP[i] = '0; hD[i] = '0; h1[i] = '0; h2[i] = '0;
    end
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (issueValid !== '0 || rollbackCnt !== '0) begin
      failures++;
      $display("FAIL R1: valid=%b rb=%0d expected valid=000 rb=0", issueValid, rollbackCnt);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 independent group
    setSlot(0, 1, 32'h100, 5'd1, 5'd10, 5'd11);
    setSlot(1, 1, 32'h104, 5'd2, 5'd12, 5'd13);
    setSlot(2, 1, 32'h108, 5'd3, 5'd14, 5'd15);
    step("R2", 0);
    // R3 zero destination creates no dependency
    setSlot(0, 1, 32'h10c, 5'd0, 5'd1, 5'd2);
    setSlot(1, 1, 32'h110, 5'd6, 5'd0, 5'd0);
    setSlot(2, 1, 32'h114, 5'd7, 5'd3, 5'd0);
    step("R3", 0);
    // R3 invalid older slot creates no dependency
    setSlot(0, 0, 32'h118, 5'd5, 5'd1, 5'd1);
    setSlot(1, 1, 32'h11c, 5'd8, 5'd5, 5'd2);
    setSlot(2, 1, 32'h120, 5'd9, 5'd2, 5'd5);
    step("R3", 0);
    // R4 slot 1 reads slot 0 via rs2: cut at 1, count 2
    setSlot(0, 1, 32'h200, 5'd4, 5'd1, 5'd2);
    setSlot(1, 1, 32'h204, 5'd10, 5'd3, 5'd4);
    setSlot(2, 1, 32'h208, 5'd11, 5'd6, 5'd7);
    step("R4", 0);
    // R5 held pair first, one new, junk in ignored slots
    clearFetch();
    setSlot(0, 1, 32'h20c, 5'd12, 5'd20, 5'd21);
    setSlot(1, 1, 32'hdead0, 5'd0, 5'd0, 5'd0);
    setSlot(2, 1, 32'hdead4, 5'd0, 5'd0, 5'd0);
    step("R5", 0);
    // R4 only slot 2 reads slot 1: count 1
    setSlot(0, 1, 32'h300, 5'd13, 5'd1, 5'd1);
    setSlot(1, 1, 32'h304, 5'd14, 5'd2, 5'd2);
    setSlot(2, 1, 32'h308, 5'd15, 5'd14, 5'd3);
    step("R4", 0);
    // R5 one held + two new
    setSlot(0, 1, 32'h30c, 5'd16, 5'd4, 5'd4);
    setSlot(1, 1, 32'h310, 5'd17, 5'd5, 5'd5);
    setSlot(2, 1, 32'hbad0, 5'd0, 5'd0, 5'd0);
    step("R5", 0);
    // R6 chain: slot1 reads slot0, slot2 reads slot1
    setSlot(0, 1, 32'h400, 5'd18, 5'd1, 5'd1);
    setSlot(1, 1, 32'h404, 5'd19, 5'd18, 5'd2);
    setSlot(2, 1, 32'h408, 5'd20, 5'd19, 5'd2);
    step("R4", 0);
    // R6 re-issued head holds its successor again
    clearFetch();
    setSlot(0, 1, 32'h40c, 5'd21, 5'd3, 5'd3);
    step("R6", 0);
    clearFetch();
    setSlot(0, 1, 32'h410, 5'd22, 5'd3, 5'd3);
    step("R6", 0);
    // R8 two slots both read slot 0
    setSlot(0, 1, 32'h500, 5'd23, 5'd1, 5'd1);
    setSlot(1, 1, 32'h504, 5'd24, 5'd23, 5'd2);
    setSlot(2, 1, 32'h508, 5'd25, 5'd2, 5'd23);
    step("R8", 0);
    clearFetch();
    setSlot(0, 1, 32'h50c, 5'd26, 5'd4, 5'd4);
    step("R8", 0);
    // R7 build a hold, then flush it
    setSlot(0, 1, 32'h600, 5'd27, 5'd1, 5'd1);
    setSlot(1, 1, 32'h604, 5'd28, 5'd27, 5'd1);
    setSlot(2, 1, 32'h608, 5'd29, 5'd1, 5'd1);
    step("R4", 0);
    clearFetch();
    setSlot(0, 1, 32'h700, 5'd1, 5'd2, 5'd2);
    step("R7", 1);
    setSlot(0, 1, 32'h800, 5'd1, 5'd2, 5'd3);
    setSlot(1, 1, 32'h804, 5'd2, 5'd3, 5'd4);
    setSlot(2, 1, 32'h808, 5'd3, 5'd4, 5'd5);
    step("R7", 0);
    clearFetch();
    step("R2", 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule